// File: doc/BRIEF.md
# Machine Status and Interrupt Control Registers

This block keeps the privilege state and the interrupt control registers of a small processor core that runs in only two privilege levels, machine and user. The pipeline reaches three registers through a simple CSR port: a status register, an interrupt-enable register and an interrupt-pending register. Writes take effect at the next clock edge. Reads are combinational from the stored state.

Devices drive raw interrupt request lines. The pending register is a registered copy of those lines and cannot be written. A pending bit therefore clears only when the device withdraws its request after being serviced. Software can hold off an interrupt by clearing its enable bit.

The pipeline sends strobes for trap entry and trap return. The block answers with the current privilege level, a single masked request to take an interrupt, and a flag that marks a wait-for-interrupt instruction as illegal when the wait-trap control is set and the core is not in machine mode.

Top module: `pcsr_top`

## Requirements
- R1: After reset the core is in machine mode (`priv_m_o`=1). The status, enable and pending registers all read 0, and `irq_take_o` and `wfi_illegal_o` are 0.
- R2: The status register sits at address 0x300. It implements four fields: bit 21 is the wait-trap control, bits 12:11 are the previous privilege level (11 = machine, 00 = user), bit 7 is the saved interrupt enable, and bit 3 is the global interrupt enable. Every other bit reads 0 and ignores writes.
- R3: A write to the previous-privilege field stores 11 only when the written value is 11. Any other value is stored as 00.
- R4: The pending register sits at address 0x344. Request line i appears at bit 16+i one clock after it is sampled. All other bits read 0.
- R5: CSR writes to the pending register have no effect on its contents.
- R6: The enable register sits at address 0x304 and uses the same bit positions as the pending register. All other bits read 0.
- R7: `irq_take_o` is 1 exactly when some pending bit and its enable bit are both set, and either the global enable is set or the core is in user mode.
- R8: On trap entry the saved enable takes the global enable, the global enable clears, and the previous-privilege field records the current level. The core then enters machine mode.
- R9: On trap return the global enable takes the saved enable, the saved enable becomes 1, and the core moves to the level held in the previous-privilege field. That field then becomes 00.
- R10: `wfi_illegal_o` is 1 exactly when `wfi_i` is high, the wait-trap control is set, and the core is in user mode.
- R11: When several updates arrive in the same cycle, trap entry wins over trap return, and trap return wins over a CSR write to the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data for `csr_addr_i` |
| irq_i | input | NUM_IRQ | Raw device interrupt requests |
| trap_enter_i | input | 1 | Trap entry strobe |
| trap_return_i | input | 1 | Trap return strobe |
| wfi_i | input | 1 | Wait-for-interrupt instruction executing |
| priv_m_o | output | 1 | 1 = machine mode, 0 = user mode |
| irq_take_o | output | 1 | Masked interrupt-take request |
| wfi_illegal_o | output | 1 | Wait instruction is illegal at this level |

## Verification
The assertions check the following relations on every cycle:
- the pending register read image equals the request lines of the previous cycle, and its unused bits stay 0;
- a take request implies that some request line was high;
- an illegal-wait flag never appears in machine mode;
- trap entry always leaves the core in machine mode.

Some behaviour can only be shown by the bench's scenarios:
- legalisation of the previous-privilege field;
- the exact field moves on trap entry and trap return;
- the masking interplay between the global enable and user mode;
- the priority of simultaneous updates.

// File: rtl/priv_csr_pkg.sv
package priv_csr_pkg;
  localparam logic [11:0] ADDR_STAT  = 12'h300;
  localparam logic [11:0] ADDR_IEN   = 12'h304;
  localparam logic [11:0] ADDR_IPEND = 12'h344;

  localparam int POS_WTRAP = 21;
  localparam int POS_PLVL  = 11;
  localparam int POS_SVIE  = 7;
  localparam int POS_GIE   = 3;

  localparam logic [1:0] LVL_M = 2'b11;
  localparam logic [1:0] LVL_U = 2'b00;

  typedef struct packed {
    logic       wtrap;
    logic [1:0] plvl;
    logic       svie;
    logic       gie;
  } stat_t;

  function automatic stat_t stat_from_word(input logic [31:0] w);
    stat_t s;
    s.wtrap = w[POS_WTRAP];
    s.plvl  = w[POS_PLVL+1:POS_PLVL];
    s.svie  = w[POS_SVIE];
    s.gie   = w[POS_GIE];
    return s;
  endfunction

  function automatic logic [31:0] stat_to_word(input stat_t s);
    logic [31:0] w;
    w = '0;
    w[POS_WTRAP]            = s.wtrap;
    w[POS_PLVL+1:POS_PLVL]  = s.plvl;
    w[POS_SVIE]             = s.svie;
    w[POS_GIE]              = s.gie;
    return w;
  endfunction
endpackage

// File: rtl/pcsr_rst_sync.sv
module pcsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/pcsr_status.sv
module pcsr_status
  import priv_csr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  stat_t wr_val_i,
  input  logic  trap_enter_i,
  input  logic  trap_return_i,
  output stat_t stat_o,
  output logic  priv_m_o
);
  stat_t stat_q, stat_d;
  logic  priv_q, priv_d;
  logic  upd_en;

  // Next state: entry > return > software write
  always_comb begin
    stat_d = stat_q;
    priv_d = priv_q;
    upd_en = 1'b0;
    if (trap_enter_i) begin
      upd_en      = 1'b1;
      stat_d.svie = stat_q.gie;
      stat_d.gie  = 1'b0;
      stat_d.plvl = priv_q ? LVL_M : LVL_U;
      priv_d      = 1'b1;
    end else if (trap_return_i) begin
      upd_en      = 1'b1;
      stat_d.gie  = stat_q.svie;
      stat_d.svie = 1'b1;
      priv_d      = (stat_q.plvl == LVL_M);
      stat_d.plvl = LVL_U;
    end else if (wr_en_i) begin
      upd_en      = 1'b1;
      stat_d      = wr_val_i;
      stat_d.plvl = (wr_val_i.plvl == LVL_M) ? LVL_M : LVL_U;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      priv_q <= 1'b1;
    end else if (upd_en) begin
      stat_q <= stat_d;
      priv_q <= priv_d;
    end
  end

  assign stat_o   = stat_q;
  assign priv_m_o = priv_q;
endmodule

// File: rtl/pcsr_irq.sv
module pcsr_irq #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_we_i,
  input  logic [NUM_IRQ-1:0] en_wval_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic [NUM_IRQ-1:0] en_o,
  output logic [NUM_IRQ-1:0] pend_o
);
  logic [NUM_IRQ-1:0] en_q;
  logic [NUM_IRQ-1:0] pend_q;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic en_d;
    logic pend_d;

    always_comb begin
      en_d   = en_we_i ? en_wval_i[i] : en_q[i];
      pend_d = irq_i[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[i]   <= 1'b0;
        pend_q[i] <= 1'b0;
      end else begin
        en_q[i]   <= en_d;
        pend_q[i] <= pend_d;
      end
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/pcsr_rdmux.sv
module pcsr_rdmux
  import priv_csr_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int IRQ_LSB = 16
) (
  input  logic [11:0]        addr_i,
  input  stat_t              stat_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] pend_i,
  output logic [31:0]        rdata_o
);
  logic [31:0] en_word;
  logic [31:0] pend_word;

  always_comb begin
    en_word   = '0;
    pend_word = '0;
    en_word[IRQ_LSB +: NUM_IRQ]   = en_i;
    pend_word[IRQ_LSB +: NUM_IRQ] = pend_i;
  end

  always_comb begin
    case (addr_i)
      ADDR_STAT:  rdata_o = stat_to_word(stat_i);
      ADDR_IEN:   rdata_o = en_word;
      ADDR_IPEND: rdata_o = pend_word;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pcsr_top.sv
module pcsr_top
  import priv_csr_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int IRQ_LSB = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csr_we_i,
  input  logic [11:0]        csr_addr_i,
  input  logic [31:0]        csr_wdata_i,
  output logic [31:0]        csr_rdata_o,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               trap_enter_i,
  input  logic               trap_return_i,
  input  logic               wfi_i,
  output logic               priv_m_o,
  output logic               irq_take_o,
  output logic               wfi_illegal_o
);
  logic               rst_int_n;
  logic               stat_we;
  logic               ien_we;
  stat_t              stat;
  logic [NUM_IRQ-1:0] en_vec;
  logic [NUM_IRQ-1:0] pend_vec;
  logic               priv_m;

  pcsr_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  assign stat_we = csr_we_i && (csr_addr_i == ADDR_STAT);
  assign ien_we  = csr_we_i && (csr_addr_i == ADDR_IEN);

  pcsr_status u_stat (
    .clk_i         (clk_i),
    .rst_ni        (rst_int_n),
    .wr_en_i       (stat_we),
    .wr_val_i      (stat_from_word(csr_wdata_i)),
    .trap_enter_i  (trap_enter_i),
    .trap_return_i (trap_return_i),
    .stat_o        (stat),
    .priv_m_o      (priv_m)
  );

  pcsr_irq #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .en_we_i   (ien_we),
    .en_wval_i (csr_wdata_i[IRQ_LSB +: NUM_IRQ]),
    .irq_i     (irq_i),
    .en_o      (en_vec),
    .pend_o    (pend_vec)
  );

  pcsr_rdmux #(.NUM_IRQ(NUM_IRQ), .IRQ_LSB(IRQ_LSB)) u_rd (
    .addr_i  (csr_addr_i),
    .stat_i  (stat),
    .en_i    (en_vec),
    .pend_i  (pend_vec),
    .rdata_o (csr_rdata_o)
  );

  assign priv_m_o      = priv_m;
  assign irq_take_o    = (|(pend_vec & en_vec)) && (stat.gie || !priv_m);
  assign wfi_illegal_o = wfi_i && stat.wtrap && !priv_m;
endmodule

// File: rtl/pcsr_chk.sv
module pcsr_chk
  import priv_csr_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int IRQ_LSB = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [11:0]        csr_addr_i,
  input logic [31:0]        csr_rdata_o,
  input logic [NUM_IRQ-1:0] irq_i,
  input logic               trap_enter_i,
  input logic               priv_m_o,
  input logic               irq_take_o,
  input logic               wfi_illegal_o
);
  localparam logic [31:0] PEND_MASK = ((32'h1 << NUM_IRQ) - 32'h1) << IRQ_LSB;

  logic [1:0] up_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  // R4
  pend_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt == 2'd3 && csr_addr_i == ADDR_IPEND) |->
      (csr_rdata_o[IRQ_LSB +: NUM_IRQ] == $past(irq_i)));

  // R4
  pend_zero_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i == ADDR_IPEND) |-> ((csr_rdata_o & ~PEND_MASK) == 32'h0));

  // R7
  take_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> (|$past(irq_i)));

  // R10
  wfi_user_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wfi_illegal_o |-> !priv_m_o);

  // R8
  entry_machine_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_enter_i |=> priv_m_o);
endmodule

bind pcsr_top pcsr_chk #(.NUM_IRQ(NUM_IRQ), .IRQ_LSB(IRQ_LSB)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .csr_addr_i    (csr_addr_i),
  .csr_rdata_o   (csr_rdata_o),
  .irq_i         (irq_i),
  .trap_enter_i  (trap_enter_i),
  .priv_m_o      (priv_m_o),
  .irq_take_o    (irq_take_o),
  .wfi_illegal_o (wfi_illegal_o)
);

// File: tb/test_pcsr_top.sv
module test_pcsr_top;
  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  irq = '0;
  logic        ent = 1'b0;
  logic        ret = 1'b0;
  logic        wfi = 1'b0;
  logic        priv_m;
  logic        take;
  logic        ill;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    logic [31:0] rd;
    logic        take;
    logic        priv;
    logic        ill;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_T/2) clk = ~clk;

  pcsr_top i_pcsr_top (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .irq_i(irq),
    .trap_enter_i(ent), .trap_return_i(ret), .wfi_i(wfi),
    .priv_m_o(priv_m), .irq_take_o(take), .wfi_illegal_o(ill)
  );

  task automatic drv(input logic w, input logic [11:0] a, input logic [31:0] d,
                     input logic [7:0] rq, input logic en, input logic rt,
                     input logic wf);
    @(negedge clk);
    we = w; addr = a; wdata = d; irq = rq; ent = en; ret = rt; wfi = wf;
  endtask

  task automatic expect_now(input string tag, input logic [31:0] rd,
                            input logic tk, input logic pv, input logic il);
    exp_t e;
    e.tag = tag; e.rd = rd; e.take = tk; e.priv = pv; e.ill = il;
    sb_q.push_back(e);
  endtask

  // Monitor: compares queued expectations a quarter period after each drive
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_T/4);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (rdata !== e.rd || take !== e.take || priv_m !== e.priv || ill !== e.ill) begin
          errors++;
          $display("FAIL %s: rd=%h take=%b priv=%b ill=%b expected rd=%h take=%b priv=%b ill=%b",
                   e.tag, rdata, take, priv_m, ill, e.rd, e.take, e.priv, e.ill);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) drv(0, 12'h300, 0, 0, 0, 0, 0);
    // R1 reset state
    drv(0, 12'h300, 0, 0, 0, 0, 0); expect_now("R1 status", 32'h0, 0, 1, 0);
    drv(0, 12'h304, 0, 0, 0, 0, 0); expect_now("R1 enable", 32'h0, 0, 1, 0);
    drv(0, 12'h344, 0, 0, 0, 0, 0); expect_now("R1 pending", 32'h0, 0, 1, 0);
    // R2 fields and unused bits
    drv(1, 12'h300, 32'hFFFF_FFFF, 0, 0, 0, 0);
    drv(0, 12'h300, 0, 0, 0, 0, 0); expect_now("R2 all ones", 32'h0020_1888, 0, 1, 0);
    // R3 legalisation
    drv(1, 12'h300, 32'h0000_1000, 0, 0, 0, 0);
    drv(0, 12'h300, 0, 0, 0, 0, 0); expect_now("R3 lvl 10", 32'h0, 0, 1, 0);
    drv(1, 12'h300, 32'h0000_0800, 0, 0, 0, 0);
    drv(0, 12'h300, 0, 0, 0, 0, 0); expect_now("R3 lvl 01", 32'h0, 0, 1, 0);
    drv(1, 12'h300, 32'h0000_1800, 0, 0, 0, 0);
    drv(0, 12'h300, 0, 0, 0, 0, 0); expect_now("R3 lvl 11", 32'h0000_1800, 0, 1, 0);
    // R4 latency and mapping
    drv(0, 12'h344, 0, 8'h05, 0, 0, 0); expect_now("R4 before latch", 32'h0, 0, 1, 0);
    drv(0, 12'h344, 0, 8'h05, 0, 0, 0); expect_now("R4 latched", 32'h0005_0000, 0, 1, 0);
    // R5 write ignored
    drv(1, 12'h344, 32'hFFFF_FFFF, 8'h05, 0, 0, 0);
    drv(0, 12'h344, 0, 8'h05, 0, 0, 0); expect_now("R5 write ignored", 32'h0005_0000, 0, 1, 0);
    drv(0, 12'h344, 0, 8'h00, 0, 0, 0); expect_now("R4 still held", 32'h0005_0000, 0, 1, 0);
    drv(0, 12'h344, 0, 8'h00, 0, 0, 0); expect_now("R4 dropped", 32'h0, 0, 1, 0);
    // R6 enable register
    drv(1, 12'h304, 32'hFFFF_FFFF, 0, 0, 0, 0);
    drv(0, 12'h304, 0, 0, 0, 0, 0); expect_now("R6 enable mask", 32'h00FF_0000, 0, 1, 0);
    // R7 masking
    drv(0, 12'h300, 0, 8'h01, 0, 0, 0);
    drv(0, 12'h300, 0, 8'h01, 0, 0, 0); expect_now("R7 gie off machine", 32'h0000_1800, 0, 1, 0);
    drv(1, 12'h300, 32'h0000_1808, 8'h01, 0, 0, 0);
    drv(0, 12'h300, 0, 8'h01, 0, 0, 0); expect_now("R7 gie on", 32'h0000_1808, 1, 1, 0);
    drv(1, 12'h304, 32'h0, 8'h01, 0, 0, 0);
    drv(0, 12'h304, 0, 8'h01, 0, 0, 0); expect_now("R7 enable masks", 32'h0, 0, 1, 0);
    drv(1, 12'h304, 32'hFFFF_FFFF, 8'h00, 0, 0, 0);
    drv(0, 12'h300, 0, 8'h00, 0, 0, 0); expect_now("R7 no request", 32'h0000_1808, 0, 1, 0);
    // R9 trap return to machine, then to user
    drv(0, 12'h300, 0, 0, 0, 1, 0);
    drv(0, 12'h300, 0, 0, 0, 0, 0); expect_now("R9 return to M", 32'h0000_0080, 0, 1, 0);
    drv(0, 12'h300, 0, 0, 0, 1, 0);
    drv(0, 12'h300, 0, 0, 0, 0, 0); expect_now("R9 return to U", 32'h0000_0088, 0, 0, 0);
    // R10 wait legality
    drv(0, 12'h300, 0, 0, 0, 0, 1); expect_now("R10 trap off", 32'h0000_0088, 0, 0, 0);
    drv(1, 12'h300, 32'h0020_0088, 0, 0, 0, 0);
    drv(0, 12'h300, 0, 0, 0, 0, 1); expect_now("R10 user illegal", 32'h0020_0088, 0, 0, 1);
    // R7 user mode ignores global enable
    drv(1, 12'h300, 32'h0020_0080, 8'h02, 0, 0, 0);
    drv(0, 12'h300, 0, 8'h02, 0, 0, 0); expect_now("R7 user take", 32'h0020_0080, 1, 0, 0);
    // R8 trap entry from user
    drv(0, 12'h300, 0, 8'h02, 1, 0, 0);
    drv(0, 12'h300, 0, 8'h02, 0, 0, 1); expect_now("R8 entry R10 machine", 32'h0020_0000, 0, 1, 0);
    // R11 priority
    drv(1, 12'h300, 32'h0000_0008, 8'h00, 1, 1, 0);
    drv(0, 12'h300, 0, 0, 0, 0, 0); expect_now("R11 entry wins", 32'h0020_1800, 0, 1, 0);
    drv(1, 12'h300, 32'h0000_0008, 8'h00, 0, 1, 0);
    drv(0, 12'h300, 0, 0, 0, 0, 0); expect_now("R11 return wins", 32'h0020_0080, 0, 1, 0);
    drv(0, 12'h300, 0, 0, 0, 0, 0);
    drv(0, 12'h300, 0, 0, 0, 0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule